// File: doc/BRIEF.md
# SMI Cause Status Register Block

This block keeps the record that system management interrupt (SMI) handler firmware reads to learn why it was entered. It holds an SMI enable register and an SMI status register. Both sit on a simple register bus that has an address, write data, a write strobe, a read strobe and read data. Two cause sources feed the block. The first is a write to the APM control port. The second is a TCO event: either the watchdog timer runs out, or software writes the TCO data-in register, which is also held here.

When an enabled source fires, the block latches a sticky cause bit and pulses the SMI request output for one cycle. Firmware reads the status word and handles the cause. It then writes ones to the bits it has handled, which clears them. Bits written as zero, and every status bit the block does not own, stay as they are.

The software data-in path always raises a TCO cause, whatever the enable register holds. It also sets a software flag in a small TCO status word, and that flag is cleared by writing one to it.

Top module: `smi_cause_regs`

## Requirements
- R1: After reset, every readable register (enable at 0x30, status at 0x34, data-in at 0x64, TCO status at 0x68) reads 0, and smi_req_o is low.
- R2: A write to the enable register at 0x30 changes only the bits set in the writable mask EN_WMASK (default 0x0000FFFF). All other enable bits keep their earlier value.
- R3: An APM port event (apm_wr_i high for a cycle) with enable bit 5 set makes status bit 5 read 1. With enable bit 5 clear, status bit 5 stays 0 and no SMI is requested.
- R4: A timer expiry (tco_expire_i high for a cycle) with enable bit 13 set makes status bit 13 read 1. With enable bit 13 clear, status bit 13 stays 0 and no SMI is requested.
- R5: A write to the data-in register at 0x64 latches the low 8 bits of write data. It also sets TCO status bit 3 at 0x68, sets status bit 13 and requests an SMI, whatever the enable register holds.
- R6: A write to the status register clears bit 5 and bit 13 where the written bit is 1. Bits written as 0 keep their value, and writes to the other bit positions have no effect.
- R7: If a cause bit is set by an event and cleared by a status write in the same cycle, the bit reads 1 afterwards.
- R8: smi_req_o is high for exactly the one cycle after the clock edge that samples an enabled event or a data-in write. That is the same cycle in which the status bit first reads 1.
- R9: Reads have no side effects. With bus_rd_i low, bus_rdata_o is 0. An unmapped address reads 0.
- R10: Writing 1 to bit 3 of the TCO status register at 0x68 clears the software flag. Writing 0 there leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| bus_addr_i | input | 8 | Register byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_rd_i | input | 1 | Read strobe |
| bus_rdata_o | output | 32 | Read data, valid while bus_rd_i is high |
| apm_wr_i | input | 1 | Pulse: the APM control port was written |
| tco_expire_i | input | 1 | Pulse: the TCO watchdog timer expired |
| smi_req_o | output | 1 | One-cycle SMI request |

## Verification
Each register is one flop deep. A wrong cause bit, enable bit or software flag therefore appears on a read of its address in the first cycle after the edge that corrupted it. A cause that is lost, or one that appears without reason, also shows as a missing or extra smi_req_o pulse in that same cycle. The same-cycle set and clear case is the one place a wrong priority hides from every other test. A combined clear write with an event shows it as a cleared bit 13 with a pulse beside it.

// File: rtl/smi_cause_pkg.sv
package smi_cause_pkg;

    // Bit positions that handler firmware decodes
    localparam int unsigned APMC_BIT   = 5;
    localparam int unsigned TCO_BIT    = 13;
    localparam int unsigned SW_TCO_BIT = 3;

    // Index of each cause inside the sticky cause vector
    localparam int unsigned N_CAUSE    = 2;
    localparam int unsigned CAUSE_APMC = 0;
    localparam int unsigned CAUSE_TCO  = 1;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_EN,
        SEL_STS,
        SEL_DIN,
        SEL_TSTS
    } reg_sel_e;

endpackage

// File: rtl/smi_addr_decode.sv
module smi_addr_decode
    import smi_cause_pkg::*;
#(
    parameter int unsigned        ADDR_W   = 8,
    parameter logic [ADDR_W-1:0]  OFF_EN   = 8'h30,
    parameter logic [ADDR_W-1:0]  OFF_STS  = 8'h34,
    parameter logic [ADDR_W-1:0]  OFF_DIN  = 8'h64,
    parameter logic [ADDR_W-1:0]  OFF_TSTS = 8'h68
) (
    input  logic [ADDR_W-1:0] addr_i,
    output reg_sel_e          sel_o
);

    always_comb begin
        if (addr_i == OFF_EN)        sel_o = SEL_EN;
        else if (addr_i == OFF_STS)  sel_o = SEL_STS;
        else if (addr_i == OFF_DIN)  sel_o = SEL_DIN;
        else if (addr_i == OFF_TSTS) sel_o = SEL_TSTS;
        else                         sel_o = SEL_NONE;
    end

endmodule

// File: rtl/smi_enable_reg.sv
module smi_enable_reg #(
    parameter int unsigned        DATA_W = 32,
    parameter logic [DATA_W-1:0]  WMASK  = 32'h0000_FFFF
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] en_o
);

    typedef struct packed {
        logic [DATA_W-1:0] en;
    } en_state_t;

    en_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_i) begin
            s_d.en = (s_q.en & ~WMASK) | (wdata_i & WMASK);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign en_o = s_q.en;

    // R2: bits outside the writable mask never move
    a_r2_mask_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((en_o & ~WMASK) == ($past(en_o) & ~WMASK)));

    // R2: a write lands on the writable bits
    a_r2_mask_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_i |=> ((en_o & WMASK) == ($past(wdata_i) & WMASK)));

endmodule

// File: rtl/smi_cause_status.sv
module smi_cause_status #(
    parameter int unsigned N_CAUSE = 2
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [N_CAUSE-1:0] set_i,
    input  logic [N_CAUSE-1:0] clr_i,
    output logic [N_CAUSE-1:0] cause_o,
    output logic               smi_req_o
);

    typedef struct packed {
        logic [N_CAUSE-1:0] cause;
        logic               req;
    } sts_state_t;

    sts_state_t         s_d, s_q;
    logic [N_CAUSE-1:0] cause_nxt;

    for (genvar g = 0; g < N_CAUSE; g++) begin : g_cause
        // set has priority over a same-cycle clear
        assign cause_nxt[g] = set_i[g] | (s_q.cause[g] & ~clr_i[g]);

        // R7: a set always survives to the next cycle
        a_r7_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
            set_i[g] |=> cause_o[g]);

        // R6: a clear with no competing set empties the bit
        a_r6_w1c_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (clr_i[g] && !set_i[g]) |=> !cause_o[g]);

        // R6: with neither set nor clear the bit holds
        a_r6_sticky_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!clr_i[g] && !set_i[g]) |=> $stable(cause_o[g]));
    end

    always_comb begin
        s_d       = s_q;
        s_d.cause = cause_nxt;
        s_d.req   = |set_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign cause_o   = s_q.cause;
    assign smi_req_o = s_q.req;

    // R8: a request only follows an accepted set, and shows a set cause
    a_r8_req_follows_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
        smi_req_o |-> ($past(|set_i) && (|cause_o)));

endmodule

// File: rtl/tco_swdata_reg.sv
module tco_swdata_reg #(
    parameter int unsigned DIN_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             din_wr_i,
    input  logic [DIN_W-1:0] din_wdata_i,
    input  logic             flag_clr_i,
    output logic [DIN_W-1:0] din_o,
    output logic             sw_flag_o,
    output logic             sw_evt_o
);

    typedef struct packed {
        logic [DIN_W-1:0] din;
        logic             flag;
    } swd_state_t;

    swd_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (din_wr_i) begin
            s_d.din = din_wdata_i;
        end
        s_d.flag = din_wr_i | (s_q.flag & ~flag_clr_i);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign din_o     = s_q.din;
    assign sw_flag_o = s_q.flag;
    assign sw_evt_o  = din_wr_i;

    // R5: the written byte is captured and the flag raised
    a_r5_din_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
        din_wr_i |=> ((din_o == $past(din_wdata_i)) && sw_flag_o));

    // R10: a clear with no new write drops the flag
    a_r10_flag_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_clr_i && !din_wr_i) |=> !sw_flag_o);

endmodule

// File: rtl/smi_cause_regs.sv
module smi_cause_regs
    import smi_cause_pkg::*;
#(
    parameter int unsigned        ADDR_W   = 8,
    parameter int unsigned        DATA_W   = 32,
    parameter int unsigned        DIN_W    = 8,
    parameter logic [DATA_W-1:0]  EN_WMASK = 32'h0000_FFFF,
    parameter logic [ADDR_W-1:0]  OFF_EN   = 8'h30,
    parameter logic [ADDR_W-1:0]  OFF_STS  = 8'h34,
    parameter logic [ADDR_W-1:0]  OFF_DIN  = 8'h64,
    parameter logic [ADDR_W-1:0]  OFF_TSTS = 8'h68
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    input  logic              apm_wr_i,
    input  logic              tco_expire_i,
    output logic              smi_req_o
);

    localparam int unsigned PAD_DIN = DATA_W - DIN_W;

    reg_sel_e           sel;
    logic [DATA_W-1:0]  en_q;
    logic [N_CAUSE-1:0] cause_set, cause_clr, cause_q;
    logic [DIN_W-1:0]   din_q;
    logic               sw_flag_q, sw_evt;
    logic               wr_en, wr_sts, wr_din, wr_tsts;

    smi_addr_decode #(
        .ADDR_W  (ADDR_W),
        .OFF_EN  (OFF_EN),
        .OFF_STS (OFF_STS),
        .OFF_DIN (OFF_DIN),
        .OFF_TSTS(OFF_TSTS)
    ) u_decode (
        .addr_i(bus_addr_i),
        .sel_o (sel)
    );

    assign wr_en   = bus_wr_i && (sel == SEL_EN);
    assign wr_sts  = bus_wr_i && (sel == SEL_STS);
    assign wr_din  = bus_wr_i && (sel == SEL_DIN);
    assign wr_tsts = bus_wr_i && (sel == SEL_TSTS);

    smi_enable_reg #(
        .DATA_W(DATA_W),
        .WMASK (EN_WMASK)
    ) u_enable (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .wr_i   (wr_en),
        .wdata_i(bus_wdata_i),
        .en_o   (en_q)
    );

    tco_swdata_reg #(
        .DIN_W(DIN_W)
    ) u_swdata (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .din_wr_i   (wr_din),
        .din_wdata_i(bus_wdata_i[DIN_W-1:0]),
        .flag_clr_i (wr_tsts && bus_wdata_i[SW_TCO_BIT]),
        .din_o      (din_q),
        .sw_flag_o  (sw_flag_q),
        .sw_evt_o   (sw_evt)
    );

    always_comb begin
        cause_set             = '0;
        cause_clr             = '0;
        cause_set[CAUSE_APMC] = apm_wr_i && en_q[APMC_BIT];
        cause_set[CAUSE_TCO]  = (tco_expire_i && en_q[TCO_BIT]) || sw_evt;
        cause_clr[CAUSE_APMC] = wr_sts && bus_wdata_i[APMC_BIT];
        cause_clr[CAUSE_TCO]  = wr_sts && bus_wdata_i[TCO_BIT];
    end

    smi_cause_status #(
        .N_CAUSE(N_CAUSE)
    ) u_status (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .set_i    (cause_set),
        .clr_i    (cause_clr),
        .cause_o  (cause_q),
        .smi_req_o(smi_req_o)
    );

    always_comb begin
        bus_rdata_o = '0;
        if (bus_rd_i) begin
            case (sel)
                SEL_EN:   bus_rdata_o = en_q;
                SEL_STS: begin
                    bus_rdata_o[APMC_BIT] = cause_q[CAUSE_APMC];
                    bus_rdata_o[TCO_BIT]  = cause_q[CAUSE_TCO];
                end
                SEL_DIN:  bus_rdata_o = {{PAD_DIN{1'b0}}, din_q};
                SEL_TSTS: bus_rdata_o[SW_TCO_BIT] = sw_flag_q;
                default:  bus_rdata_o = '0;
            endcase
        end
    end

    // R3: a disabled APM event never raises the cause bit
    a_r3_apm_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!cause_q[CAUSE_APMC] && !(apm_wr_i && en_q[APMC_BIT])) |=> !cause_q[CAUSE_APMC]);

    // R4: an enabled expiry is recorded and requested
    a_r4_expiry_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tco_expire_i && en_q[TCO_BIT]) |=> (cause_q[CAUSE_TCO] && smi_req_o));

    // R5: a data-in write raises the TCO cause regardless of enable
    a_r5_sw_sets_tco: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_din |=> (cause_q[CAUSE_TCO] && smi_req_o));

    // R9: the read port stays quiet without a read strobe
    a_r9_idle_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !bus_rd_i |-> (bus_rdata_o == '0));

endmodule

// File: tb/smi_cause_regs_bench.sv
module smi_cause_regs_bench;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] A_EN   = 8'h30;
    localparam logic [7:0] A_STS  = 8'h34;
    localparam logic [7:0] A_DIN  = 8'h64;
    localparam logic [7:0] A_TSTS = 8'h68;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [31:0] rdata;
    logic        apm = 1'b0;
    logic        tco = 1'b0;
    logic        smi;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    smi_cause_regs u_smi_cause_regs (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_wr_i    (wr),
        .bus_rd_i    (rd),
        .bus_rdata_o (rdata),
        .apm_wr_i    (apm),
        .tco_expire_i(tco),
        .smi_req_o   (smi)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr = 1'b1;
        tick();
        wr = 1'b0; wdata = '0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        addr = a; rd = 1'b1;
        #1;
        d = rdata;
        rd = 1'b0;
        #1;
    endtask

    task automatic read_check(input string tag, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        bus_read(a, v);
        check(tag, v, exp);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic t_reset();
        do_reset();
        read_check("R1 enable", A_EN, 32'h0);
        read_check("R1 status", A_STS, 32'h0);
        read_check("R1 data-in", A_DIN, 32'h0);
        read_check("R1 tco status", A_TSTS, 32'h0);
        check("R1 smi idle", {31'b0, smi}, 32'h0);
    endtask

    task automatic t_enable_mask();
        bus_write(A_EN, 32'hFFFF_FFFF);
        read_check("R2 masked write", A_EN, 32'h0000_FFFF);
        bus_write(A_EN, 32'h00A5_0000);
        read_check("R2 high bits ignored", A_EN, 32'h0000_0000);
        bus_write(A_EN, 32'h0000_0000);
    endtask

    task automatic t_apm();
        // R3: disabled event leaves no trace
        apm = 1'b1; tick(); apm = 1'b0;
        check("R3 no smi when disabled", {31'b0, smi}, 32'h0);
        read_check("R3 no cause when disabled", A_STS, 32'h0);
        bus_write(A_EN, 32'h0000_0020);
        apm = 1'b1; tick(); apm = 1'b0;
        check("R8 smi pulse on apm", {31'b0, smi}, 32'h1);
        read_check("R3 apm cause", A_STS, 32'h0000_0020);
        tick();
        check("R8 pulse single cycle", {31'b0, smi}, 32'h0);
        bus_write(A_STS, 32'h0000_0020);
        bus_write(A_EN, 32'h0);
    endtask

    task automatic t_tco();
        bus_write(A_EN, 32'h0000_0020);
        tco = 1'b1; tick(); tco = 1'b0;
        check("R4 no smi when disabled", {31'b0, smi}, 32'h0);
        read_check("R4 no cause when disabled", A_STS, 32'h0);
        bus_write(A_EN, 32'h0000_2000);
        apm = 1'b1; tick(); apm = 1'b0;
        check("R3 apm gated by bit 5 only", {31'b0, smi}, 32'h0);
        tco = 1'b1; tick(); tco = 1'b0;
        check("R8 smi pulse on expiry", {31'b0, smi}, 32'h1);
        read_check("R4 tco cause", A_STS, 32'h0000_2000);
        bus_write(A_STS, 32'h0000_2000);
        bus_write(A_EN, 32'h0);
    endtask

    task automatic t_swdin();
        bus_write(A_DIN, 32'h0000_01A5);
        check("R5 smi on data-in write", {31'b0, smi}, 32'h1);
        read_check("R5 data latched", A_DIN, 32'h0000_00A5);
        read_check("R5 sw flag", A_TSTS, 32'h0000_0008);
        read_check("R5 tco cause without enable", A_STS, 32'h0000_2000);
        bus_write(A_TSTS, 32'hFFFF_FFF7);
        read_check("R10 zero keeps flag", A_TSTS, 32'h0000_0008);
        bus_write(A_TSTS, 32'h0000_0008);
        read_check("R10 one clears flag", A_TSTS, 32'h0);
        bus_write(A_STS, 32'h0000_2000);
    endtask

    task automatic t_w1c();
        bus_write(A_EN, 32'h0000_2020);
        apm = 1'b1; tco = 1'b1; tick(); apm = 1'b0; tco = 1'b0;
        read_check("R6 both set", A_STS, 32'h0000_2020);
        bus_write(A_STS, 32'hFFFF_DFDF);
        read_check("R6 other bits no effect", A_STS, 32'h0000_2020);
        bus_write(A_STS, 32'h0000_0020);
        read_check("R6 clear apm only", A_STS, 32'h0000_2000);
        bus_write(A_STS, 32'h0000_2000);
        read_check("R6 clear tco", A_STS, 32'h0);
    endtask

    task automatic t_collision();
        apm = 1'b1; tick(); apm = 1'b0;
        // clear both while expiry arrives
        tco = 1'b1; addr = A_STS; wdata = 32'h0000_2020; wr = 1'b1;
        tick();
        tco = 1'b0; wr = 1'b0; wdata = '0;
        check("R7 smi with collision", {31'b0, smi}, 32'h1);
        read_check("R7 set beats clear", A_STS, 32'h0000_2000);
        bus_write(A_STS, 32'h0000_2000);
        bus_write(A_EN, 32'h0);
    endtask

    task automatic t_read_side();
        logic [31:0] a, b;
        bus_write(A_DIN, 32'h0000_003C);
        bus_read(A_STS, a);
        bus_read(A_STS, b);
        check("R9 repeat read equal", b, a);
        check("R9 read keeps cause", b, 32'h0000_2000);
        read_check("R9 unmapped", 8'h40, 32'h0);
        addr = A_DIN; #1;
        check("R9 idle rdata", rdata, 32'h0);
        bus_write(A_STS, 32'h0000_2000);
        bus_write(A_TSTS, 32'h8);
        read_check("R9 cleared after reads", A_STS, 32'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        bad++; total++;
        $display("FAIL watchdog act=%h exp=%h", 32'h1, 32'h0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_enable_mask();
        t_apm();
        t_tco();
        t_swdin();
        t_w1c();
        t_collision();
        t_read_side();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule